// File: doc/BRIEF.md
# Segment Selector Validity Checker

This block decides whether a segment selector and the descriptor it names may be used for a given purpose. The purposes are a code-segment load, a stack-segment load, a return from an interrupt, a gate used by a hardware or software interrupt, the code segment an interrupt lands in, the task register load, a task-state segment reference, a global-table-only reference and a local-descriptor-table load. A pipeline stage supplies the selector, the descriptor fields that are already decoded, the current privilege level and the long-mode bit. One cycle later the block reports a fault class, whether the error code is zero or the selector, and whether the selector is null.

Each purpose has its own rules, and its own order in which faults win when several apply. For example, on a local-table load a missing descriptor is reported before a wrong type. On an interrupt return, every privilege and type violation is reported before a missing descriptor. Alongside the fault result, the block updates two zero-style condition flags from the null test. A caller-supplied mask chooses which of the two flag bits are written.

Top module: `seg_sel_check`

## Requirements
- R1: While rst_ni is low and after it rises, valid_o, fault_o, err_sel_o, null_o and flags_o are all zero until the first accepted request.
- R2: A request is accepted when valid_i is high at a rising clock edge, and its results appear after that edge with valid_o high. While valid_i is low, valid_o is low and fault_o, err_sel_o, null_o and flags_o hold their values.
- R3: A selector is null when bits 15:2 are all zero, whatever its RPL (bits 1:0). Bit 2 is the table indicator. For each flag bit i, flags_o[i] equals null_o if mask_i[i] is set and flags_i[i] otherwise.
- R4: The fault_o codes are 0 none, 1 general protection, 2 stack fault and 3 not present. err_sel_o is 1 when the error code is the selector and 0 when it is zero, and it is 0 when there is no fault. The kind_i codes are 0 none, 1 code, 2 call gate, 3 interrupt gate, 4 software interrupt gate, 5 stack, 6 iret, 7 interrupt code segment, 8 task register, 9 TSS, 10 global-table, 11 local-table. Kind 0 never faults. Kind 2 and kinds 12 to 15 give general protection with a zero code.
- R5: Descriptor type bit 3 set means code. For a code type, bit 2 means conforming. For a data type, bit 1 means writable. Kind 1 gives general protection with a zero code when desc_s_i is 0, when the type is not code, or when DPL differs from CPL.
- R6: Kind 3 gives general protection with a zero code unless type bits 2 and 1 are both set and, in long mode, type bit 3 is also set.
- R7: Kind 4 gives general protection with the selector when DPL is below CPL. Otherwise it applies the kind 3 rules.
- R8: Kind 5 gives general protection with the selector when the descriptor is not a writable data segment, or when DPL or RPL differs from CPL. Failing that, a clear present bit gives a stack fault with the selector.
- R9: Kind 6 gives general protection with the selector on a null selector, on RPL below CPL, on a non-code descriptor, on a non-conforming code segment whose DPL differs from RPL, or on a conforming code segment whose DPL exceeds RPL. Failing those, a clear present bit gives not present with the selector.
- R10: Kind 7 in long mode gives general protection with the selector unless L is 1 and D is 0. Outside long mode it never faults.
- R11: Kind 8 checks three conditions in order, and each gives the fault named with the selector as the error code. A null selector or a set table indicator gives general protection. A clear present bit gives not present. Any type other than 9 gives general protection.
- R12: Kind 9 gives not present with the selector on a clear present bit, and otherwise general protection with the selector unless the type is 9 or 11. Kind 10 gives general protection with the selector when the table indicator is set.
- R13: Kind 11 gives not present with the selector on a clear present bit. Otherwise it gives general protection with the selector unless the type is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| kind_i | input | 4 | Check purpose code |
| sel_i | input | 16 | Selector (RPL 1:0, table indicator 2, index 15:3) |
| desc_s_i | input | 1 | Descriptor non-system bit |
| desc_type_i | input | 4 | Descriptor type field |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| desc_p_i | input | 1 | Descriptor present bit |
| desc_l_i | input | 1 | Descriptor 64-bit code bit |
| desc_d_i | input | 1 | Descriptor default-size bit |
| cpl_i | input | 2 | Current privilege level |
| long_mode_i | input | 1 | Long mode active |
| flags_i | input | 2 | Current zero-style flags |
| mask_i | input | 2 | Which flag bits to write |
| valid_o | output | 1 | Result strobe |
| fault_o | output | 2 | Fault class |
| err_sel_o | output | 1 | Error code is the selector |
| null_o | output | 1 | Selector was null |
| flags_o | output | 2 | Updated flags |

## Verification
Each purpose code is exercised with one passing descriptor, and then with descriptors that break one rule at a time. This shows that each rule can fault on its own and that the error-code choice differs between rules. Inputs that break two rules at once, such as a missing local-table descriptor that also has a wrong type, or a task-register selector that is both missing and mistyped, show which fault takes priority. Selectors that carry only RPL bits, and selectors that carry only the table indicator, separate the null test from the table-indicator test. Idle cycles with changing inputs show that the results are held.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned KIND_W = 4;
  localparam int unsigned TYPE_W = 4;

  typedef enum logic [KIND_W-1:0] {
    CHK_NONE    = 4'd0,
    CHK_CODE    = 4'd1,
    CHK_CALLG   = 4'd2,
    CHK_INTG    = 4'd3,
    CHK_SOFTG   = 4'd4,
    CHK_STACK   = 4'd5,
    CHK_IRET    = 4'd6,
    CHK_INTCS   = 4'd7,
    CHK_TASKR   = 4'd8,
    CHK_TSS     = 4'd9,
    CHK_GLOBAL  = 4'd10,
    CHK_LOCAL   = 4'd11
  } chk_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_GP    = 2'd1,
    FLT_STACK = 2'd2,
    FLT_NP    = 2'd3
  } fault_e;

  typedef struct packed {
    fault_e fault;
    logic   err_sel;
  } chk_res_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             null_o,
  output logic             ti_o,
  output logic [1:0]       rpl_o
);
  assign rpl_o  = sel_i[1:0];
  assign ti_o   = sel_i[2];
  // null ignores RPL only
  assign null_o = ~|sel_i[SEL_W-1:2];
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              sel_null_i,
  input  logic              sel_ti_i,
  input  logic [1:0]        rpl_i,
  input  logic              desc_s_i,
  input  logic [TYPE_W-1:0] desc_type_i,
  input  logic [1:0]        desc_dpl_i,
  input  logic              desc_p_i,
  input  logic              desc_l_i,
  input  logic              desc_d_i,
  input  logic [1:0]        cpl_i,
  input  logic              long_mode_i,
  output chk_res_t          res_o
);
  logic code_seg, conforming, wr_data, gate_ok, lm_cs_bad;

  assign code_seg   = desc_s_i & desc_type_i[3];
  assign conforming = desc_type_i[2];
  assign wr_data    = desc_s_i & ~desc_type_i[3] & desc_type_i[1];
  assign gate_ok    = desc_type_i[2] & desc_type_i[1] &
                      (~long_mode_i | desc_type_i[3]);
  assign lm_cs_bad  = long_mode_i & ~(desc_l_i & ~desc_d_i);

  always_comb begin
    res_o = '{fault: FLT_NONE, err_sel: 1'b0};
    case (kind_i)
      CHK_NONE: ;
      CHK_CODE:
        if (!code_seg || desc_dpl_i != cpl_i) res_o = '{FLT_GP, 1'b0};
      CHK_INTG, CHK_SOFTG: begin
        if (kind_i == CHK_SOFTG && desc_dpl_i < cpl_i) res_o = '{FLT_GP, 1'b1};
        else if (!gate_ok)                             res_o = '{FLT_GP, 1'b0};
      end
      CHK_STACK: begin
        if (!wr_data || desc_dpl_i != cpl_i || rpl_i != cpl_i) res_o = '{FLT_GP, 1'b1};
        else if (!desc_p_i)                                    res_o = '{FLT_STACK, 1'b1};
      end
      CHK_IRET: begin
        if (sel_null_i || rpl_i < cpl_i || !code_seg ||
            (!conforming && desc_dpl_i != rpl_i) ||
            (conforming && desc_dpl_i > rpl_i))     res_o = '{FLT_GP, 1'b1};
        else if (!desc_p_i)                         res_o = '{FLT_NP, 1'b1};
      end
      CHK_INTCS:
        if (lm_cs_bad) res_o = '{FLT_GP, 1'b1};
      CHK_TASKR: begin
        if (sel_null_i || sel_ti_i)       res_o = '{FLT_GP, 1'b1};
        else if (!desc_p_i)               res_o = '{FLT_NP, 1'b1};
        else if (desc_type_i != 4'h9)     res_o = '{FLT_GP, 1'b1};
      end
      CHK_TSS: begin
        if (!desc_p_i)                    res_o = '{FLT_NP, 1'b1};
        else if (desc_type_i != 4'h9 && desc_type_i != 4'hB)
                                          res_o = '{FLT_GP, 1'b1};
      end
      CHK_GLOBAL:
        if (sel_ti_i) res_o = '{FLT_GP, 1'b1};
      CHK_LOCAL: begin
        if (!desc_p_i)                    res_o = '{FLT_NP, 1'b1};
        else if (desc_type_i != 4'h2)     res_o = '{FLT_GP, 1'b1};
      end
      default: res_o = '{FLT_GP, 1'b0};
    endcase
  end
endmodule

// File: rtl/seg_flag_merge.sv
module seg_flag_merge #(
  parameter int unsigned FLAG_W = 2
) (
  input  logic              set_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    assign flags_o[i] = mask_i[i] ? set_i : flags_i[i];
  end
endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_chk_pkg::*;
#(
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned FLAG_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              desc_s_i,
  input  logic [TYPE_W-1:0] desc_type_i,
  input  logic [1:0]        desc_dpl_i,
  input  logic              desc_p_i,
  input  logic              desc_l_i,
  input  logic              desc_d_i,
  input  logic [1:0]        cpl_i,
  input  logic              long_mode_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic              valid_o,
  output logic [1:0]        fault_o,
  output logic              err_sel_o,
  output logic              null_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic              sel_null, sel_ti;
  logic [1:0]        rpl;
  chk_res_t          res;
  logic [FLAG_W-1:0] flags_nx;

  seg_sel_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_i), .null_o(sel_null), .ti_o(sel_ti), .rpl_o(rpl)
  );

  seg_rule_eval u_eval (
    .kind_i      (kind_i),
    .sel_null_i  (sel_null),
    .sel_ti_i    (sel_ti),
    .rpl_i       (rpl),
    .desc_s_i    (desc_s_i),
    .desc_type_i (desc_type_i),
    .desc_dpl_i  (desc_dpl_i),
    .desc_p_i    (desc_p_i),
    .desc_l_i    (desc_l_i),
    .desc_d_i    (desc_d_i),
    .cpl_i       (cpl_i),
    .long_mode_i (long_mode_i),
    .res_o       (res)
  );

  seg_flag_merge #(.FLAG_W(FLAG_W)) u_flags (
    .set_i(sel_null), .flags_i(flags_i), .mask_i(mask_i), .flags_o(flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      fault_o   <= 2'd0;
      err_sel_o <= 1'b0;
      null_o    <= 1'b0;
      flags_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fault_o   <= res.fault;
        err_sel_o <= res.err_sel;
        null_o    <= sel_null;
        flags_o   <= flags_nx;
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(fault_o) && $stable(err_sel_o) &&
                  $stable(null_o) && $stable(flags_o)));

  assert_unmasked_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((flags_o & ~$past(mask_i)) == ($past(flags_i) & ~$past(mask_i))));

  assert_no_fault_zero_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_NONE) |-> !err_sel_o);

  assert_none_kind_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == CHK_NONE) |=> fault_o == FLT_NONE);

  assert_code_dpl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == CHK_CODE && desc_dpl_i != cpl_i) |=>
      (fault_o == FLT_GP && !err_sel_o));

  assert_stack_fault_kind_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i != CHK_STACK) |=> fault_o != FLT_STACK);

  assert_iret_null_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == CHK_IRET && sel_i[SEL_W-1:2] == '0) |=>
      (fault_o == FLT_GP && err_sel_o));
endmodule

// File: tb/tb_seg_sel_check.sv
module tb_seg_sel_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  kind_i = '0;
  logic [15:0] sel_i = '0;
  logic        desc_s_i = 1'b0;
  logic [3:0]  desc_type_i = '0;
  logic [1:0]  desc_dpl_i = '0;
  logic        desc_p_i = 1'b0;
  logic        desc_l_i = 1'b0;
  logic        desc_d_i = 1'b0;
  logic [1:0]  cpl_i = '0;
  logic        long_mode_i = 1'b0;
  logic [1:0]  flags_i = '0;
  logic [1:0]  mask_i = '0;
  logic        valid_o, err_sel_o, null_o;
  logic [1:0]  fault_o, flags_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  seg_sel_check dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one request, check result one edge later
  task automatic req(input string tag, input logic [3:0] k, input logic [15:0] sel,
                     input logic s, input logic [3:0] ty, input logic [1:0] dpl,
                     input logic p, input logic l, input logic d,
                     input logic [1:0] cpl, input logic lm,
                     input int exp_fault, input int exp_err);
    logic nul;
    @(negedge clk_i);
    valid_i = 1'b1; kind_i = k; sel_i = sel; desc_s_i = s; desc_type_i = ty;
    desc_dpl_i = dpl; desc_p_i = p; desc_l_i = l; desc_d_i = d; cpl_i = cpl;
    long_mode_i = lm;
    @(negedge clk_i);
    valid_i = 1'b0;
    nul = (sel[15:2] == 14'd0);
    chk({tag, " fault"}, int'(fault_o), exp_fault);
    chk({tag, " err"}, int'(err_sel_o), exp_err);
    chk({tag, " valid"}, int'(valid_o), 1);
    chk("R3 null", int'(null_o), int'(nul));
    chk("R3 flags", int'(flags_o), int'((flags_i & ~mask_i) | (nul ? mask_i : 2'b00)));
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 fault", int'(fault_o), 0);
    chk("R1 err", int'(err_sel_o), 0);
    chk("R1 null", int'(null_o), 0);
    chk("R1 flags", int'(flags_o), 0);
  endtask

  task automatic t_flags;
    flags_i = 2'b00; mask_i = 2'b11;
    req("R4 none-kind rpl-only null", 4'd0, 16'h0003, 0, 4'h0, 2'd0, 0, 0, 0, 2'd3, 0, 0, 0);
    flags_i = 2'b10; mask_i = 2'b01;
    req("R3 partial mask", 4'd0, 16'h0008, 0, 4'h0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0);
    flags_i = 2'b00; mask_i = 2'b10;
    req("R3 ti not null", 4'd0, 16'h0004, 0, 4'h0, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0);
    flags_i = 2'b01; mask_i = 2'b00;
  endtask

  task automatic t_code;
    req("R5 ok", 4'd1, 16'h0008, 1, 4'hA, 2'd0, 1, 0, 0, 2'd0, 0, 0, 0);
    req("R5 system", 4'd1, 16'h0008, 0, 4'hA, 2'd0, 1, 0, 0, 2'd0, 0, 1, 0);
    req("R5 data", 4'd1, 16'h0008, 1, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 1, 0);
    req("R5 dpl", 4'd1, 16'h0008, 1, 4'hA, 2'd3, 1, 0, 0, 2'd0, 0, 1, 0);
  endtask

  task automatic t_unsup;
    req("R4 call gate", 4'd2, 16'h0008, 0, 4'hC, 2'd0, 1, 0, 0, 2'd0, 0, 1, 0);
    req("R4 code 13", 4'd13, 16'h0008, 1, 4'hA, 2'd0, 1, 0, 0, 2'd0, 0, 1, 0);
  endtask

  task automatic t_gates;
    req("R6 lm ok", 4'd3, 16'h0010, 0, 4'hE, 2'd0, 1, 0, 0, 2'd0, 1, 0, 0);
    req("R6 bad type", 4'd3, 16'h0010, 0, 4'hC, 2'd0, 1, 0, 0, 2'd0, 1, 1, 0);
    req("R6 legacy ok", 4'd3, 16'h0010, 0, 4'h6, 2'd0, 1, 0, 0, 2'd0, 0, 0, 0);
    req("R6 lm 16bit", 4'd3, 16'h0010, 0, 4'h6, 2'd0, 1, 0, 0, 2'd0, 1, 1, 0);
    req("R7 dpl<cpl", 4'd4, 16'h0010, 0, 4'hE, 2'd0, 1, 0, 0, 2'd3, 1, 1, 1);
    req("R7 pass", 4'd4, 16'h0010, 0, 4'hE, 2'd3, 1, 0, 0, 2'd3, 1, 0, 0);
    req("R7 falls to type", 4'd4, 16'h0010, 0, 4'h4, 2'd3, 1, 0, 0, 2'd0, 0, 1, 0);
  endtask

  task automatic t_stack;
    req("R8 ok", 4'd5, 16'h0010, 1, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 0, 0);
    req("R8 readonly", 4'd5, 16'h0010, 1, 4'h0, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    req("R8 rpl", 4'd5, 16'h0011, 1, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    req("R8 not present", 4'd5, 16'h0010, 1, 4'h2, 2'd0, 0, 0, 0, 2'd0, 0, 2, 1);
    req("R8 gp beats np", 4'd5, 16'h0010, 1, 4'h2, 2'd1, 0, 0, 0, 2'd0, 0, 1, 1);
  endtask

  task automatic t_iret;
    req("R9 null", 4'd6, 16'h0000, 1, 4'hA, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    req("R9 rpl<cpl", 4'd6, 16'h0018, 1, 4'hA, 2'd0, 1, 0, 0, 2'd3, 0, 1, 1);
    req("R9 nonconf dpl", 4'd6, 16'h001B, 1, 4'hA, 2'd2, 1, 0, 0, 2'd3, 0, 1, 1);
    req("R9 conf ok", 4'd6, 16'h001B, 1, 4'hE, 2'd2, 1, 0, 0, 2'd3, 0, 0, 0);
    req("R9 conf dpl>rpl", 4'd6, 16'h001A, 1, 4'hE, 2'd3, 1, 0, 0, 2'd2, 0, 1, 1);
    req("R9 not present", 4'd6, 16'h001B, 1, 4'hA, 2'd3, 0, 0, 0, 2'd3, 0, 3, 1);
  endtask

  task automatic t_intcs;
    req("R10 lm ok", 4'd7, 16'h0008, 1, 4'hA, 2'd0, 1, 1, 0, 2'd0, 1, 0, 0);
    req("R10 lm d set", 4'd7, 16'h0008, 1, 4'hA, 2'd0, 1, 1, 1, 2'd0, 1, 1, 1);
    req("R10 legacy", 4'd7, 16'h0008, 1, 4'hA, 2'd0, 1, 0, 1, 2'd0, 0, 0, 0);
  endtask

  task automatic t_task;
    req("R11 ti", 4'd8, 16'h000C, 0, 4'h9, 2'd0, 1, 0, 0, 2'd0, 1, 1, 1);
    req("R11 null", 4'd8, 16'h0002, 0, 4'h9, 2'd0, 1, 0, 0, 2'd0, 1, 1, 1);
    req("R11 np beats type", 4'd8, 16'h0028, 0, 4'hB, 2'd0, 0, 0, 0, 2'd0, 1, 3, 1);
    req("R11 busy type", 4'd8, 16'h0028, 0, 4'hB, 2'd0, 1, 0, 0, 2'd0, 1, 1, 1);
    req("R11 ok", 4'd8, 16'h0028, 0, 4'h9, 2'd0, 1, 0, 0, 2'd0, 1, 0, 0);
    req("R12 tss busy ok", 4'd9, 16'h0028, 0, 4'hB, 2'd0, 1, 0, 0, 2'd0, 1, 0, 0);
    req("R12 tss type", 4'd9, 16'h0028, 0, 4'h1, 2'd0, 1, 0, 0, 2'd0, 1, 1, 1);
    req("R12 tss np", 4'd9, 16'h0028, 0, 4'h1, 2'd0, 0, 0, 0, 2'd0, 1, 3, 1);
    req("R12 global ti", 4'd10, 16'h002C, 1, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    req("R12 global ok", 4'd10, 16'h0028, 1, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 0, 0);
  endtask

  task automatic t_local;
    req("R13 np beats type", 4'd11, 16'h0030, 0, 4'h5, 2'd0, 0, 0, 0, 2'd0, 0, 3, 1);
    req("R13 type", 4'd11, 16'h0030, 0, 4'h5, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    req("R13 ok", 4'd11, 16'h0030, 0, 4'h2, 2'd0, 1, 0, 0, 2'd0, 0, 0, 0);
  endtask

  task automatic t_hold;
    flags_i = 2'b00; mask_i = 2'b11;
    req("R2 setup", 4'd11, 16'h0030, 0, 4'h5, 2'd0, 1, 0, 0, 2'd0, 0, 1, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      kind_i = 4'd0; sel_i = 16'h0000; flags_i = 2'b01; desc_p_i = 1'b0;
    end
    @(negedge clk_i);
    chk("R2 idle valid", int'(valid_o), 0);
    chk("R2 hold fault", int'(fault_o), 1);
    chk("R2 hold err", int'(err_sel_o), 1);
    chk("R2 hold null", int'(null_o), 0);
    chk("R2 hold flags", int'(flags_o), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_flags();
    t_code();
    t_unsup();
    t_gates();
    t_stack();
    t_iret();
    t_intcs();
    t_task();
    t_local();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule